// File: doc/BRIEF.md
# Run-Time Configurable Serial Frame Receiver

This block recovers asynchronous serial words from a single line. Its frame shape, bit duration, resting line polarity and the placement of the sampling window inside each bit are all inputs, so one instance can follow a different link setup after every reconfiguration. A bit lasts `bit_period` system clocks. Each bit is split into sixteen sub-ticks, and a small set of consecutive sub-tick samples is majority-voted into one bit value.

A frame is a start bit at the non-idle level, then five to eight data bits with the least significant bit first. An optional even or odd parity bit follows, and the frame closes with one, one and a half or two stop bits at the idle level. Each received word appears for one clock with a valid strobe. A parity mismatch or a bad stop bit raises a flag in that same clock. Buffering of words and any register access are left to the surrounding logic.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset `rx_valid`, `parity_err`, `frame_err` and `rx_data` are 0, and no word is produced until a frame is received with `enable` high.
- R2: The line passes through two flops. The first clock in which the synchronized line sits at the non-idle level starts a frame. Every bit then lasts `bit_period` clocks, and the word is presented at the end of the last checked stop bit.
- R3: A sub-tick is floor(`bit_period`/16) clocks. One sample is taken in the first clock of each sub-tick from `sample_start` up to and including min(15, `sample_start` + max(`sample_count`,1) − 1). The bit value is the majority of the samples, and a tie resolves to the idle level.
- R4: `width_sel` 3'b101, 3'b110 and 3'b111 select 5, 6 and 7 data bits, and every other value selects 8. The first received data bit lands in `rx_data[0]`, and bits above the selected width read 0.
- R5: With `parity_en` high, a parity bit follows the data. `parity_odd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets `parity_err` together with `rx_valid`. With `parity_en` low, `parity_err` stays 0.
- R6: `stop_sel` 2'b00 selects one stop bit, 2'b01 one and a half, and 2'b10 or 2'b11 two. Every checked stop bit that votes to the non-idle level sets `frame_err` with `rx_valid`, and the word is still delivered.
- R7: With one and a half stop bits, only the first stop bit is checked. The word is presented at its end, and the receiver then waits floor(`bit_period`/2) clocks before it hunts for a start bit again.
- R8: If the start bit votes to the idle level, the receiver drops the frame silently and hunts again, with no strobe and no flag.
- R9: `idle_level` sets the resting level. The start bit is its inverse and stop bits must equal it. Data and parity bits are taken at their sampled values in either polarity.
- R10: While `enable` is low the line is ignored, and a frame in progress is abandoned without output.
- R11: `rx_valid` is a single-cycle pulse, and `parity_err` and `frame_err` are never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input |
| enable | input | 1 | Receiver enable |
| bit_period | input | 16 | Clocks per bit, at least 32 |
| width_sel | input | 3 | Data width code |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| stop_sel | input | 2 | Stop bit count code |
| idle_level | input | 1 | Resting level of the line |
| sample_start | input | 4 | First sampled sub-tick |
| sample_count | input | 4 | Number of sampled sub-ticks |
| rx_data | output | 8 | Received word, held between strobes |
| rx_valid | output | 1 | One-cycle word strobe |
| parity_err | output | 1 | Parity mismatch, with the strobe |
| frame_err | output | 1 | Bad stop bit, with the strobe |

## Verification
Frames are sent at several widths, with each parity type in its good and corrupted form, with every stop-bit count, and in both idle polarities. This separates errors in bit ordering, width masking, parity sense and stop handling. Glitches placed inside one data bit hit one sample, two samples, or only clocks outside the window. These cases tell a correct majority vote with idle-level tie-breaking apart from a single-point sampler or a window that is misplaced or clipped wrongly. A short start pulse, a frame cut off by dropping `enable`, and back-to-back frames after one and a half stop bits check rejection, abandonment and the half-bit hold-off.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          enable,
  input  logic [PW-1:0] bit_period,
  input  logic [2:0]    width_sel,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic [1:0]    stop_sel,
  input  logic          idle_level,
  input  logic [3:0]    sample_start,
  input  logic [3:0]    sample_count,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  output logic          parity_err,
  output logic          frame_err
);
  localparam int SW = PW - 4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_GAP} st_t;
  st_t st;

  logic [1:0]    sync;
  logic [PW-1:0] bc;
  logic [SW-1:0] sc;
  logic [4:0]    ti;
  logic [3:0]    ones, taken;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          perr_acc, ferr_acc;

  wire          line    = sync[1];
  wire [SW-1:0] sub     = bit_period[PW-1:4];
  wire [PW-1:0] len     = (st == S_GAP) ? {1'b0, bit_period[PW-1:1]} : bit_period;
  wire          bit_end = (bc == len - 1'b1);
  wire [3:0]    cnt_eff = (sample_count == 4'd0) ? 4'd1 : sample_count;
  wire [4:0]    win_end = {1'b0, sample_start} + {1'b0, cnt_eff};
  wire          take    = (sc == '0) && (ti != 5'd16) && (ti >= {1'b0, sample_start}) && (ti < win_end);
  wire [4:0]    ones2   = {ones, 1'b0};
  wire          vote    = (ones2 > {1'b0, taken}) ? 1'b1 :
                          (ones2 < {1'b0, taken}) ? 1'b0 : idle_level;
  wire [3:0]    nbits   = (width_sel[2] && (width_sel[1] || width_sel[0])) ? {1'b0, width_sel} : 4'd8;
  wire          bad_stop = (vote != idle_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc <= '0; sc <= '0; ti <= '0; ones <= '0; taken <= '0;
    end else if (st == S_IDLE || bit_end) begin
      bc <= '0; sc <= '0; ti <= '0; ones <= '0; taken <= '0;
    end else begin
      bc <= bc + 1'b1;
      if (sc == sub - 1'b1) begin
        sc <= '0;
        if (ti != 5'd16) ti <= ti + 5'd1;
      end else begin
        sc <= sc + 1'b1;
      end
      if (take) begin
        ones  <= ones + {3'b000, line};
        taken <= taken + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitn <= '0; shreg <= '0; perr_acc <= 1'b0; ferr_acc <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; parity_err <= 1'b0; frame_err <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      if (!enable) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (line != idle_level) begin
            st <= S_START; bitn <= '0; shreg <= '0; perr_acc <= 1'b0; ferr_acc <= 1'b0;
          end
          S_START: if (bit_end) st <= (vote == idle_level) ? S_IDLE : S_DATA;
          S_DATA: if (bit_end) begin
            shreg[bitn] <= vote;
            bitn <= bitn + 3'd1;
            if ({1'b0, bitn} == nbits - 4'd1) st <= parity_en ? S_PAR : S_STOP1;
          end
          S_PAR: if (bit_end) begin
            perr_acc <= ((^shreg) ^ vote) != parity_odd;
            st <= S_STOP1;
          end
          S_STOP1: if (bit_end) begin
            if (stop_sel[1]) begin
              ferr_acc <= bad_stop;
              st <= S_STOP2;
            end else begin
              rx_valid <= 1'b1; rx_data <= shreg;
              parity_err <= perr_acc; frame_err <= bad_stop;
              st <= (stop_sel[0]) ? S_GAP : S_IDLE;
            end
          end
          S_STOP2: if (bit_end) begin
            rx_valid <= 1'b1; rx_data <= shreg;
            parity_err <= perr_acc; frame_err <= ferr_acc | bad_stop;
            st <= S_IDLE;
          end
          S_GAP: if (bit_end) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       parity_en,
  input logic [2:0] width_sel,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       parity_err,
  input logic       frame_err
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R11
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (parity_err || frame_err) |-> rx_valid); // R11
  AST_PARITY_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) parity_err |-> $past(parity_en)); // R5
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) $past(!enable) |-> !rx_valid); // R10
  AST_NARROW_WORD: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && width_sel == 3'b101) |-> rx_data[7:5] == 3'b000); // R4
endmodule

bind uart_frame_rx uart_frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .parity_en(parity_en), .width_sel(width_sel),
  .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
);

// File: tb/uart_frame_rx_test.sv
`timescale 1ns/1ps
module uart_frame_rx_test;
  logic clk = 0, rst_n = 0, rx_line = 1, enable = 0;
  logic [15:0] bit_period = 16'd64;
  logic [2:0] width_sel = 3'd0;
  logic parity_en = 0, parity_odd = 0, idle_level = 1;
  logic [1:0] stop_sel = 2'd0;
  logic [3:0] sample_start = 4'd6, sample_count = 4'd4;
  logic [7:0] rx_data;
  logic rx_valid, parity_err, frame_err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] wq[$];

  uart_frame_rx uut (.*);

  always #2 clk = ~clk;

  // behavioural reference, advanced on every rising edge
  int m_ph = 0, m_cnt = 0, m_ones = 0, m_taken = 0, m_bits = 0;
  bit m_s1 = 1, m_s2 = 1, m_perr = 0, m_ferr = 0;
  bit m_valid = 0, m_pe = 0, m_fe = 0;
  logic [7:0] m_data = 0, m_dout = 0;

  always @(posedge clk) begin
    int sub, L, tk, ce, nb;
    bit lv, v;
    if (!rst_n) begin
      m_ph = 0; m_s1 = 1; m_s2 = 1; m_valid = 0; m_pe = 0; m_fe = 0; m_dout = 0;
    end else begin
      lv = m_s2; m_s2 = m_s1; m_s1 = rx_line;
      m_valid = 0; m_pe = 0; m_fe = 0;
      if (!enable) m_ph = 0;
      else if (m_ph == 0) begin
        if (lv != idle_level) begin
          m_ph = 1; m_cnt = 0; m_ones = 0; m_taken = 0;
          m_data = 0; m_bits = 0; m_perr = 0; m_ferr = 0;
        end
      end else begin
        sub = bit_period / 16;
        L = (m_ph == 6) ? bit_period / 2 : bit_period;
        ce = (sample_count == 0) ? 1 : sample_count;
        if (m_ph != 6 && (m_cnt % sub) == 0) begin
          tk = m_cnt / sub;
          if (tk < 16 && tk >= sample_start && tk < sample_start + ce) begin
            m_ones += lv; m_taken++;
          end
        end
        if (m_cnt == L - 1) begin
          v = (2*m_ones > m_taken) ? 1 : (2*m_ones < m_taken) ? 0 : idle_level;
          nb = (width_sel >= 5) ? width_sel : 8;
          m_cnt = 0; m_ones = 0; m_taken = 0;
          case (m_ph)
            1: m_ph = (v == idle_level) ? 0 : 2;
            2: begin
              m_data[m_bits] = v; m_bits++;
              if (m_bits == nb) m_ph = parity_en ? 3 : 4;
            end
            3: begin m_perr = ((^m_data) ^ v) != parity_odd; m_ph = 4; end
            4: if (stop_sel >= 2) begin m_ferr = (v != idle_level); m_ph = 5; end
               else begin
                 m_valid = 1; m_dout = m_data; m_pe = m_perr; m_fe = (v != idle_level);
                 m_ph = (stop_sel == 1) ? 6 : 0;
               end
            5: begin
              m_valid = 1; m_dout = m_data; m_pe = m_perr; m_fe = m_ferr | (v != idle_level);
              m_ph = 0;
            end
            default: m_ph = 0;
          endcase
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rx_valid !== m_valid || parity_err !== m_pe || frame_err !== m_fe ||
          (m_valid && rx_data !== m_dout)) begin
        fails++;
        $display("FAIL R2 R3 cycle model: got v=%0b d=%h pe=%0b fe=%0b expected v=%0b d=%h pe=%0b fe=%0b",
                 rx_valid, rx_data, parity_err, frame_err, m_valid, m_dout, m_pe, m_fe);
      end
      if (rx_valid) wq.push_back({parity_err, frame_err, rx_data});
    end
  end

  task automatic check_word(string tag, logic [7:0] d, bit pe, bit fe);
    logic [9:0] w;
    checks++;
    if (wq.size() == 0) begin
      fails++; $display("FAIL %s: got no word expected d=%h pe=%0b fe=%0b", tag, d, pe, fe);
    end else begin
      w = wq.pop_front();
      if (w !== {pe, fe, d}) begin
        fails++;
        $display("FAIL %s: got d=%h pe=%0b fe=%0b expected d=%h pe=%0b fe=%0b",
                 tag, w[7:0], w[9], w[8], d, pe, fe);
      end
    end
  endtask

  task automatic check_none(string tag);
    checks++;
    if (wq.size() != 0) begin
      fails++; $display("FAIL %s: got %0d words expected 0", tag, wq.size());
      wq.delete();
    end
  endtask

  task automatic drive_bit(bit v, int n, int i0, int i1);
    for (int c = 0; c < n; c++) begin
      rx_line = v ^ (c >= i0 && c < i1);
      @(negedge clk);
    end
  endtask

  task automatic idle_for(int n);
    drive_bit(idle_level, n, 0, 0);
  endtask

  task automatic send_frame(logic [7:0] d, bit bad_par, bit bad_stop, int gbit, int g0, int g1);
    int nb, P;
    bit p, s1;
    P = bit_period;
    nb = (width_sel >= 5) ? width_sel : 8;
    p = 0;
    drive_bit(~idle_level, P, 0, 0);
    for (int i = 0; i < nb; i++) begin
      drive_bit(d[i], P, (gbit == i) ? g0 : 0, (gbit == i) ? g1 : 0);
      p ^= d[i];
    end
    if (parity_en) drive_bit(p ^ parity_odd ^ bad_par, P, 0, 0);
    s1 = bad_stop ? ~idle_level : idle_level;
    drive_bit(s1, P, 0, 0);
    if (stop_sel == 2'd1) idle_for(P / 2);
    else if (stop_sel[1]) idle_for(P);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (rx_valid !== 0 || parity_err !== 0 || frame_err !== 0 || rx_data !== 0) begin
      fails++; $display("FAIL R1 reset: got %b%b%b %h expected 000 00", rx_valid, parity_err, frame_err, rx_data);
    end
    send_frame(8'h5A, 0, 0, -1, 0, 0); idle_for(128);
    check_none("R1 R10 disabled receiver");

    enable = 1; idle_for(10);
    send_frame(8'hA5, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R2 8N1", 8'hA5, 0, 0);
    send_frame(8'h3C, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R2 8N1 second", 8'h3C, 0, 0);

    width_sel = 3'b101; send_frame(8'hB3, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R4 five bits", 8'h13, 0, 0);
    width_sel = 3'b111; send_frame(8'hB3, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R4 seven bits", 8'h33, 0, 0);
    width_sel = 3'b010; send_frame(8'h81, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R4 other code is eight", 8'h81, 0, 0);
    width_sel = 3'b000;

    parity_en = 1; parity_odd = 0;
    send_frame(8'h37, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R5 even good", 8'h37, 0, 0);
    send_frame(8'h37, 1, 0, -1, 0, 0); idle_for(128);
    check_word("R5 even bad", 8'h37, 1, 0);
    parity_odd = 1;
    send_frame(8'hE1, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R5 odd good", 8'hE1, 0, 0);
    send_frame(8'hE1, 1, 0, -1, 0, 0); idle_for(128);
    check_word("R5 odd bad", 8'hE1, 1, 0);
    parity_en = 0; parity_odd = 0;

    send_frame(8'h6B, 0, 1, -1, 0, 0); idle_for(128);
    check_word("R6 one stop bad", 8'h6B, 0, 1);
    stop_sel = 2'd2;
    send_frame(8'h6B, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R6 two stops good", 8'h6B, 0, 0);
    send_frame(8'h94, 0, 1, -1, 0, 0); idle_for(128);
    check_word("R6 two stops first bad", 8'h94, 0, 1);

    stop_sel = 2'd1;
    send_frame(8'h12, 0, 0, -1, 0, 0);
    send_frame(8'h34, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R7 back to back first", 8'h12, 0, 0);
    check_word("R7 back to back second", 8'h34, 0, 0);
    send_frame(8'h56, 0, 1, -1, 0, 0); idle_for(128);
    check_word("R7 bad first stop", 8'h56, 0, 1);
    stop_sel = 2'd0;

    drive_bit(~idle_level, 3, 0, 0); idle_for(256);
    check_none("R8 short start pulse");

    drive_bit(~idle_level, 64, 0, 0); drive_bit(0, 128, 0, 0);
    enable = 0; idle_for(900); enable = 1; idle_for(128);
    check_none("R10 frame abandoned");

    idle_level = 0; idle_for(20);
    send_frame(8'hC6, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R9 low idle", 8'hC6, 0, 0);
    send_frame(8'hC6, 0, 1, -1, 0, 0); idle_for(128);
    check_word("R9 low idle bad stop", 8'hC6, 0, 1);
    idle_level = 1; idle_for(20);

    send_frame(8'h00, 0, 0, 2, 24, 28); idle_for(128);
    check_word("R3 one sample glitch outvoted", 8'h00, 0, 0);
    send_frame(8'h00, 0, 0, 2, 24, 32); idle_for(128);
    check_word("R3 tie goes to idle", 8'h04, 0, 0);
    send_frame(8'hFF, 0, 0, 5, 40, 64); idle_for(128);
    check_word("R3 glitch outside window", 8'hFF, 0, 0);
    sample_start = 4'd14;
    send_frame(8'h00, 0, 0, 1, 56, 59); idle_for(128);
    check_word("R3 clipped window tie", 8'h02, 0, 0);
    sample_start = 4'd8; sample_count = 4'd0;
    send_frame(8'h00, 0, 0, 3, 33, 34); idle_for(128);
    check_word("R3 zero count is one sample", 8'h08, 0, 0);
    sample_start = 4'd0; sample_count = 4'd2; bit_period = 16'd50;
    send_frame(8'h7E, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R3 early window odd period", 8'h7E, 0, 0);
    sample_start = 4'd6; sample_count = 4'd4; bit_period = 16'd32;
    send_frame(8'hD2, 0, 0, -1, 0, 0); idle_for(128);
    check_word("R2 minimum period", 8'hD2, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule